// File: doc/BRIEF.md
# Host-Bus Slave Port Latch

This block lets an external host processor exchange bytes with a small controller core over one 8-bit bidirectional pin group. An 8-bit holding latch sits between the two sides. The core can load it and can turn on the pin drivers. The host can write into it through an active-low chip select and write strobe. The host can also read it back through an active-low read strobe, which turns the drivers on for as long as the read lasts.

The host strobes, the chip select and the pins are asynchronous to the core, so all of them pass through a synchronizer before any decision is made. A host write is taken on the trailing (rising) edge of the write strobe. The byte captured is the one the pins carried during the last synchronized cycle of the low strobe. Each capture raises a level ready flag toward the host. That flag stays up until the core acknowledges it or loads a fresh byte.

The core also sees a synchronized copy of the pins at all times, whatever the state of the drivers.

Top module: `hbus_slave_latch`

## Requirements
- R1: While reset is high, `pad_out` is 0, `pad_oe` is 0, `host_irq` is 0 and `core_pins` is 0.
- R2: When `core_q_load` is 1 and no host capture occurs in the same cycle, `pad_out` equals `core_q_data` after the next clock edge.
- R3: With `core_drv_en` at 1, `pad_oe` is 1 one edge later. With `core_drv_en` at 0 and no host read, `pad_oe` is 0 one edge later.
- R4: A rising `host_wr_n` while `host_cs_n` is low captures the pin value into the latch. The value captured is the one present while the strobe was still low. It appears on `pad_out` exactly SYNC_STAGES+1 edges after the strobe rises, and not one edge earlier.
- R5: A write strobe pulse while `host_cs_n` is high changes neither `pad_out` nor `host_irq`.
- R6: `host_irq` becomes 1 on the same edge that a host capture updates the latch.
- R7: `host_irq` returns to 0 one edge after `core_irq_clr` or `core_q_load` is 1, provided no capture occurs in that cycle.
- R8: `host_cs_n` and `host_rd_n` both low make `pad_oe` 1 even with `core_drv_en` at 0. This takes effect SYNC_STAGES+1 edges after the strobes fall. The drivers are released SYNC_STAGES+1 edges after `host_rd_n` rises.
- R9: When a core load and a host capture fall in the same cycle, the latch takes the host byte and `host_irq` is 1.
- R10: `core_pins` shows the pin value SYNC_STAGES edges after it changes, whether or not the drivers are on.
- R11: `host_rd_n` low while `host_cs_n` is high leaves `pad_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| pad_in | input | DATA_W | Value sensed on the bidirectional pins |
| pad_out | output | DATA_W | Latch contents presented to the pin drivers |
| pad_oe | output | 1 | Pin driver enable (1 = drive) |
| core_q_load | input | 1 | Core load strobe for the latch |
| core_q_data | input | DATA_W | Byte loaded by the core |
| core_drv_en | input | 1 | Core driver enable level |
| core_irq_clr | input | 1 | Core acknowledge of the host ready flag |
| core_pins | output | DATA_W | Synchronized pin readback for the core |
| host_irq | output | 1 | Ready / interrupt flag to the host |

## Verification
The bench builds the block with DATA_W of 8 and SYNC_STAGES of 2. These values put the host-to-latch latency at three edges, so each strobe test can sample the outputs one edge before and exactly at the expected change. That exposes an extra or a missing pipeline stage. The collision test places a core load in the one cycle that carries the capture, which a two-stage synchronizer makes reachable with a fixed count of clocks.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // Idle level of the three active-low host controls
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
  } hbus_strb_t;

  localparam hbus_strb_t STRB_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_strobe_decode.sv
module hbus_strobe_decode
  import hbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  hbus_strb_t        strb_s,
  input  logic [DATA_W-1:0] pad_s,
  output logic              cap,
  output logic [DATA_W-1:0] cap_data,
  output logic              host_rd
);
  // One-cycle-old copies, aligned with each other
  logic              wr_d;
  logic              cs_d;
  logic [DATA_W-1:0] pad_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d  <= 1'b1;
      cs_d  <= 1'b1;
      pad_d <= '0;
    end else begin
      wr_d  <= strb_s.wr_n;
      cs_d  <= strb_s.cs_n;
      pad_d <= pad_s;
    end
  end

  // Trailing edge of the write strobe, chip select held low while it was low
  assign cap      = strb_s.wr_n & ~wr_d & ~cs_d;
  assign cap_data = pad_d;
  assign host_rd  = ~strb_s.cs_n & ~strb_s.rd_n;
endmodule

// File: rtl/hbus_q_latch.sv
module hbus_q_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              host_rd,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drv_en,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] q,
  output logic              oe,
  output logic              irq
);
  // Host capture has priority over the core load
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (cap)  q <= cap_data;
    else if (load) q <= load_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                   irq <= 1'b0;
    else if (cap)              irq <= 1'b1;
    else if (irq_clr || load)  irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= drv_en | host_rd;
  end
endmodule

// File: rtl/hbus_slave_latch.sv
module hbus_slave_latch
  import hbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic              pad_oe,
  input  logic              core_q_load,
  input  logic [DATA_W-1:0] core_q_data,
  input  logic              core_drv_en,
  input  logic              core_irq_clr,
  output logic [DATA_W-1:0] core_pins,
  output logic              host_irq
);
  localparam int STRB_W = $bits(hbus_strb_t);

  hbus_strb_t        strb_raw;
  hbus_strb_t        strb_s;
  logic [DATA_W-1:0] pad_s;
  logic              cap_w;
  logic [DATA_W-1:0] cap_data_w;
  logic              host_rd_w;

  assign strb_raw = '{cs_n: host_cs_n, rd_n: host_rd_n, wr_n: host_wr_n};

  hbus_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL(STRB_IDLE)) u_strb_sync (
    .clk(clk), .rst(rst), .d(strb_raw), .q(strb_s)
  );

  hbus_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pad_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_s)
  );

  hbus_strobe_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .strb_s(strb_s), .pad_s(pad_s),
    .cap(cap_w), .cap_data(cap_data_w), .host_rd(host_rd_w)
  );

  hbus_q_latch #(.DATA_W(DATA_W)) u_q (
    .clk(clk), .rst(rst), .cap(cap_w), .cap_data(cap_data_w),
    .host_rd(host_rd_w), .load(core_q_load), .load_data(core_q_data),
    .drv_en(core_drv_en), .irq_clr(core_irq_clr),
    .q(pad_out), .oe(pad_oe), .irq(host_irq)
  );

  assign core_pins = pad_s;
endmodule

// File: rtl/hbus_slave_latch_chk.sv
module hbus_slave_latch_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] pad_out,
  input logic              pad_oe,
  input logic              core_q_load,
  input logic [DATA_W-1:0] core_q_data,
  input logic              core_drv_en,
  input logic              core_irq_clr,
  input logic              host_irq,
  input logic              cap,
  input logic              host_rd
);
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    core_q_load && !cap |=> pad_out == $past(core_q_data));

  p_drv_r3: assert property (@(posedge clk) disable iff (rst)
    core_drv_en |=> pad_oe);

  p_irq_src_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq) |-> $past(cap));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cap && !core_q_load |=> $stable(pad_out));

  p_cap_irq_r6: assert property (@(posedge clk) disable iff (rst)
    cap |=> host_irq);

  p_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (core_irq_clr || core_q_load) && !cap |=> !host_irq);

  p_read_r8: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> pad_oe);

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !core_drv_en && !host_rd |=> !pad_oe);

  p_collide_r9: assert property (@(posedge clk) disable iff (rst)
    cap && core_q_load |=> host_irq);
endmodule

bind hbus_slave_latch hbus_slave_latch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .pad_out(pad_out), .pad_oe(pad_oe),
  .core_q_load(core_q_load), .core_q_data(core_q_data),
  .core_drv_en(core_drv_en), .core_irq_clr(core_irq_clr),
  .host_irq(host_irq), .cap(cap_w), .host_rd(host_rd_w)
);

// File: tb/hbus_slave_latch_tb.sv
module hbus_slave_latch_tb;
  localparam int DW = 8;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic          core_q_load = 1'b0, core_drv_en = 1'b0, core_irq_clr = 1'b0;
  logic [DW-1:0] core_q_data = '0;
  logic          host_drive = 1'b0;
  logic [DW-1:0] host_bus = '0;
  logic [DW-1:0] pad_in, pad_out, core_pins;
  logic          pad_oe, host_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  // Pin resolution: drivers, host, or pull-ups
  assign pad_in = pad_oe ? pad_out : (host_drive ? host_bus : {DW{1'b1}});

  hbus_slave_latch #(.DATA_W(DW), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .core_q_load(core_q_load), .core_q_data(core_q_data),
    .core_drv_en(core_drv_en), .core_irq_clr(core_irq_clr),
    .core_pins(core_pins), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance n rising edges, return at the following falling edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic core_load(input logic [DW-1:0] v);
    core_q_load = 1'b1; core_q_data = v;
    tick(1);
    core_q_load = 1'b0;
  endtask

  task automatic t_reset_r1();
    tick(2);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 host_irq", host_irq, 0);
    chk("R1 core_pins", core_pins, 0);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_core_load_r2();
    core_load(8'h3C);
    chk("R2 load 3C", pad_out, 8'h3C);
    core_load(8'hC3);
    chk("R2 load C3", pad_out, 8'hC3);
  endtask

  task automatic t_drv_r3();
    core_drv_en = 1'b1;
    tick(1);
    chk("R3 oe on", pad_oe, 1);
    chk("R3 out", pad_out, 8'hC3);
    core_drv_en = 1'b0;
    tick(1);
    chk("R3 oe off", pad_oe, 0);
  endtask

  // Host write; cs selects whether chip select is asserted
  task automatic host_write(input logic [DW-1:0] v, input logic cs, input logic [DW-1:0] old_q,
                            input logic collide);
    host_bus = v; host_drive = 1'b1; host_cs_n = ~cs; host_wr_n = 1'b0;
    tick(3);
    host_wr_n = 1'b1;
    tick(SS);
    chk("R4 not early", pad_out, old_q);
    if (collide) begin
      core_q_load = 1'b1; core_q_data = ~v;
    end
    tick(1);
    core_q_load = 1'b0;
    host_cs_n = 1'b1; host_drive = 1'b0;
  endtask

  task automatic t_write_r4_r6();
    host_write(8'h5A, 1'b1, 8'hC3, 1'b0);
    chk("R4 capture", pad_out, 8'h5A);
    chk("R6 irq set", host_irq, 1);
  endtask

  task automatic t_clear_r7();
    core_irq_clr = 1'b1;
    tick(1);
    core_irq_clr = 1'b0;
    chk("R7 clr ack", host_irq, 0);
    host_write(8'h96, 1'b1, 8'h5A, 1'b0);
    chk("R7 re-set", host_irq, 1);
    core_load(8'h11);
    chk("R7 clr by load", host_irq, 0);
    chk("R7 load value", pad_out, 8'h11);
  endtask

  task automatic t_nocs_r5();
    host_write(8'hEE, 1'b0, 8'h11, 1'b0);
    tick(3);
    chk("R5 q kept", pad_out, 8'h11);
    chk("R5 irq kept", host_irq, 0);
  endtask

  task automatic t_read_r8();
    host_cs_n = 1'b0; host_rd_n = 1'b0;
    tick(SS);
    chk("R8 not early", pad_oe, 0);
    tick(1);
    chk("R8 oe on", pad_oe, 1);
    chk("R8 data", pad_out, 8'h11);
    host_rd_n = 1'b1;
    tick(SS);
    chk("R8 held", pad_oe, 1);
    tick(1);
    chk("R8 released", pad_oe, 0);
    host_cs_n = 1'b1;
    tick(2);
  endtask

  task automatic t_rd_nocs_r11();
    host_rd_n = 1'b0;
    tick(5);
    chk("R11 no drive", pad_oe, 0);
    host_rd_n = 1'b1;
    tick(1);
  endtask

  task automatic t_collide_r9();
    host_write(8'h77, 1'b1, 8'h11, 1'b1);
    chk("R9 host wins", pad_out, 8'h77);
    chk("R9 irq", host_irq, 1);
    core_irq_clr = 1'b1; tick(1); core_irq_clr = 1'b0;
  endtask

  task automatic t_pins_r10();
    host_bus = 8'hA5; host_drive = 1'b1;
    tick(SS - 1);
    chk("R10 not early", core_pins, 8'hFF);
    tick(1);
    chk("R10 host pins", core_pins, 8'hA5);
    host_drive = 1'b0;
    core_drv_en = 1'b1;
    tick(SS + 1);
    chk("R10 driven pins", core_pins, 8'h77);
    core_drv_en = 1'b0;
    tick(2);
  endtask

  initial begin
    @(negedge clk);
    t_reset_r1();
    t_core_load_r2();
    t_drv_r3();
    t_write_r4_r6();
    t_clear_r7();
    t_nocs_r5();
    t_read_r8();
    t_rd_nocs_r11();
    t_collide_r9();
    t_pins_r10();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule